// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (64 x 16)

This block models a small serial EEPROM that holds 64 sixteen-bit words. A host drives chip select, a serial clock and a data-in line, and reads back on a data-out line. The block runs on its own system clock. It samples the serial pins on that clock and finds the rising edges of the serial clock internally, so the serial clock must run much slower than the system clock.

While chip select is high, a command begins with a start bit of 1. Eight command bits follow: a 2-bit opcode and then a 6-bit address. The block can read one word, or stream several in sequence. It can write one word or erase one word. When the opcode is 00, the top two address bits choose one of four extended commands: lock, unlock, fill every word with shifted-in data, and wipe every word to all ones. Any programming command has no effect unless a write-enable flag is set. After each programming command, the host drops chip select and raises it again, and the block then drives a ready level on data out.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high and no command is active, rising serial clock edges with data in at 0 are ignored. The first rising edge with data in at 1 is the start bit, and the next 8 rising edges shift in the command word MSB first.
- R2: Opcode 10 (read): after the last address bit, data out is enabled and drives a dummy 0. Each later rising serial clock edge then presents the next bit of the addressed word, MSB first.
- R3: If clocking continues past bit 0 during a read, the address increments, wrapping from 63 to 0, and the next word follows at once with no dummy bit.
- R4: Opcode 01 (write): the 16 bits that follow the command, MSB first, are stored at the addressed word.
- R5: Opcode 11 (erase): the addressed word becomes 0xFFFF.
- R6: Opcode 00 with sub-code 01 (address bits 5:4) shifts in 16 data bits and stores them in every word. Sub-code 10 sets every word to 0xFFFF.
- R7: Opcode 00 with sub-code 11 sets the write-enable flag, and sub-code 00 clears it. After reset the flag is clear and every word is 0. While the flag is clear, write, erase, fill and wipe leave the array unchanged.
- R8: After any programming command, data out stays disabled until chip select falls. Once chip select rises again, data out is enabled and drives 1 (ready) until chip select next falls.
- R9: Dropping chip select aborts any command in progress. A write cut short this way changes nothing. Whenever data out is not enabled, it is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Chip select, active high |
| serClk | input | 1 | Serial clock from the host |
| serIn | input | 1 | Serial data from the host |
| serOut | output | 1 | Serial data to the host |
| serOutEn | output | 1 | High while serOut is driven |

## Verification
The assertions assume that chip select, serial clock and data in are already synchronous to the system clock. They also assume that each serial clock level lasts several system clocks, so the decode and commit cycles always finish before the next serial edge. The bench changes the pins only on falling system clock edges and holds each serial level for four system clocks. It moves chip select only while the serial clock is low.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_WIPE   = 2'b10,
    SUB_UNLOCK = 2'b11
  } sub_e;

  typedef struct packed {
    logic shiftCmd;
    logic latchAddr;
    logic loadRead;
    logic shiftRead;
    logic shiftData;
    logic wrWord;
    logic wrAll;
    logic erWord;
    logic erAll;
    logic setWen;
    logic clrWen;
  } strobe_t;

endpackage

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSel,
  input  logic       serClk,
  input  logic       serIn,
  input  logic [3:0] cmdHead,
  input  logic       readBit,
  output strobe_t    stb,
  output logic       serOut,
  output logic       serOutEn
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int MAX_W = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W = $clog2(MAX_W);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_DECODE, S_READ, S_DATAIN,
    S_COMMIT, S_WAITFALL, S_WAITRISE, S_STATUS
  } state_e;

  state_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic skPrev, csPrev, allMode, allNext;
  logic skRise, csFall, csRise, holdOnLow;

  assign skRise    = serClk & ~skPrev;
  assign csFall    = ~chipSel & csPrev;
  assign csRise    = chipSel & ~csPrev;
  assign holdOnLow = (state == S_WAITFALL) || (state == S_WAITRISE);

  always_comb begin
    stb       = '0;
    nextState = state;
    allNext   = allMode;
    if (!chipSel && !holdOnLow) begin
      nextState = S_IDLE;
    end else begin
      case (state)
        S_IDLE:
          if (skRise && serIn) nextState = S_CMD;
        S_CMD:
          if (skRise) begin
            stb.shiftCmd = 1'b1;
            if (cnt == CNT_W'(CMD_W - 1)) nextState = S_DECODE;
          end
        S_DECODE: begin
          stb.latchAddr = 1'b1;
          case (cmdHead[3:2])
            OP_READ:  begin stb.loadRead = 1'b1; nextState = S_READ; end
            OP_WRITE: begin allNext = 1'b0; nextState = S_DATAIN; end
            OP_ERASE: begin stb.erWord = 1'b1; nextState = S_WAITFALL; end
            default:
              case (cmdHead[1:0])
                SUB_LOCK:   begin stb.clrWen = 1'b1; nextState = S_IDLE; end
                SUB_UNLOCK: begin stb.setWen = 1'b1; nextState = S_IDLE; end
                SUB_FILL:   begin allNext = 1'b1; nextState = S_DATAIN; end
                default:    begin stb.erAll = 1'b1; nextState = S_WAITFALL; end
              endcase
          endcase
        end
        S_READ:
          if (skRise) stb.shiftRead = 1'b1;
        S_DATAIN:
          if (skRise) begin
            stb.shiftData = 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) nextState = S_COMMIT;
          end
        S_COMMIT: begin
          stb.wrAll  = allMode;
          stb.wrWord = ~allMode;
          nextState  = S_WAITFALL;
        end
        S_WAITFALL:
          if (csFall) nextState = S_WAITRISE;
        S_WAITRISE:
          if (csRise) nextState = S_STATUS;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      skPrev  <= 1'b0;
      csPrev  <= 1'b0;
      allMode <= 1'b0;
    end else begin
      state   <= nextState;
      skPrev  <= serClk;
      csPrev  <= chipSel;
      allMode <= allNext;
      if (state != nextState)                cnt <= '0;
      else if (stb.shiftCmd || stb.shiftData) cnt <= cnt + 1'b1;
    end
  end

  assign serOutEn = (state == S_READ) || (state == S_STATUS);
  assign serOut   = (state == S_READ) ? readBit : (state == S_STATUS);

endmodule

// File: rtl/mw_eeprom_dp.sv
module mw_eeprom_dp
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serIn,
  input  strobe_t               stb,
  output logic [ADDR_W+1:0]     cmdWord,
  output logic                  readBit,
  output logic                  wenFlag
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int WORDS = 1 << ADDR_W;
  localparam int RC_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] addrReg, cmdAddr, nextAddr;
  logic [DATA_W-1:0] readSh, dataSh;
  logic [RC_W-1:0]   readCnt;

  assign cmdAddr  = cmdWord[ADDR_W-1:0];
  assign nextAddr = addrReg + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0;
      addrReg <= '0;
      readSh  <= '0;
      readBit <= 1'b0;
      readCnt <= '0;
      dataSh  <= '0;
      wenFlag <= 1'b0;
    end else begin
      if (stb.shiftCmd)  cmdWord <= {cmdWord[CMD_W-2:0], serIn};
      if (stb.latchAddr) addrReg <= cmdAddr;
      if (stb.loadRead) begin
        readSh  <= mem[cmdAddr];
        readBit <= 1'b0;
        readCnt <= '0;
      end
      if (stb.shiftRead) begin
        readBit <= readSh[DATA_W-1];
        if (readCnt == RC_W'(DATA_W - 1)) begin
          addrReg <= nextAddr;
          readSh  <= mem[nextAddr];
          readCnt <= '0;
        end else begin
          readSh  <= {readSh[DATA_W-2:0], 1'b0};
          readCnt <= readCnt + 1'b1;
        end
      end
      if (stb.shiftData) dataSh <= {dataSh[DATA_W-2:0], serIn};
      if (stb.setWen) wenFlag <= 1'b1;
      if (stb.clrWen) wenFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wenFlag) begin
      if (stb.wrWord) mem[addrReg] <= dataSh;
      if (stb.erWord) mem[cmdAddr] <= '1;
      if (stb.wrAll || stb.erAll)
        for (int i = 0; i < WORDS; i++) mem[i] <= stb.erAll ? '1 : dataSh;
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  output logic serOut,
  output logic serOutEn
);
  localparam int CMD_W = ADDR_W + 2;

  strobe_t          stb;
  logic [CMD_W-1:0] cmdWord;
  logic             readBit;
  logic             wenFlag;

  mw_eeprom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .cmdHead(cmdWord[CMD_W-1 -: 4]), .readBit(readBit), .stb(stb),
    .serOut(serOut), .serOutEn(serOutEn)
  );

  mw_eeprom_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .stb(stb),
    .cmdWord(cmdWord), .readBit(readBit), .wenFlag(wenFlag)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_eeprom_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    chipSel,
  input logic    serOut,
  input logic    serOutEn,
  input strobe_t stb,
  input logic    wenFlag
);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !serOutEn |-> !serOut);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !serOutEn);

  assert_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serOutEn) |-> chipSel);

  assert_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrWen |=> !wenFlag);

  assert_unlock_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.setWen |=> wenFlag);

  assert_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrWord, stb.wrAll, stb.erWord, stb.erAll}));

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .serOut(serOut),
  .serOutEn(serOutEn), .stb(stb), .wenFlag(wenFlag)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  logic clk = 1'b0;
  logic rstN, chipSel, serClk, serIn;
  logic serOut, serOutEn;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom u0 (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic so);
    serIn = b;
    tick(4);
    serClk = 1'b1;
    tick(4);
    so = serOut;
    serClk = 1'b0;
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [5:0] addr, output logic lastOut);
    logic [7:0] w;
    logic so;
    w = {op, addr};
    pulse(1'b1, so);
    for (int i = 7; i >= 0; i--) pulse(w[i], so);
    lastOut = so;
  endtask

  task automatic csUp();   chipSel = 1'b1; tick(2); endtask
  task automatic csDown(); chipSel = 1'b0; tick(4); endtask

  task automatic sendData(logic [15:0] d);
    logic so;
    for (int i = 15; i >= 0; i--) pulse(d[i], so);
  endtask

  task automatic progFinish(string req);
    tick(2);
    check({req, " disabled before toggle"}, {15'd0, serOutEn}, 16'd0);
    csDown();
    csUp();
    tick(2);
    check("R8 ready enable", {15'd0, serOutEn}, 16'd1);
    check("R8 ready level", {15'd0, serOut}, 16'd1);
    csDown();
  endtask

  task automatic ext(logic [1:0] sub);
    logic so;
    csUp();
    sendCmd(2'b00, {sub, 4'b0000}, so);
    tick(2);
    csDown();
  endtask

  task automatic writeWord(logic [5:0] a, logic [15:0] d, string req);
    logic so;
    csUp();
    sendCmd(2'b01, a, so);
    sendData(d);
    progFinish(req);
  endtask

  task automatic readWords(logic [5:0] a, int n, logic [15:0] e0, logic [15:0] e1, string req);
    logic so;
    logic [15:0] got;
    csUp();
    sendCmd(2'b10, a, so);
    check("R2 dummy bit", {15'd0, so}, 16'd0);
    check("R2 enabled during read", {15'd0, serOutEn}, 16'd1);
    for (int k = 0; k < n; k++) begin
      for (int i = 15; i >= 0; i--) begin
        pulse(1'b0, so);
        got[i] = so;
      end
      check(req, got, (k == 0) ? e0 : e1);
    end
    csDown();
  endtask

  task automatic testReset();
    check("R9 reset enable", {15'd0, serOutEn}, 16'd0);
    check("R9 reset level", {15'd0, serOut}, 16'd0);
  endtask

  task automatic testLocked();
    writeWord(6'd5, 16'h1234, "R8");
    readWords(6'd5, 1, 16'h0000, 16'h0000, "R7 locked write after reset");
  endtask

  task automatic testLeadingZeros();
    logic so;
    csUp();
    for (int i = 0; i < 3; i++) pulse(1'b0, so);
    sendCmd(2'b00, 6'b110000, so);
    tick(2);
    csDown();
    csUp();
    for (int i = 0; i < 2; i++) pulse(1'b0, so);
    sendCmd(2'b01, 6'd5, so);
    sendData(16'hA5C3);
    progFinish("R8");
    readWords(6'd5, 1, 16'hA5C3, 16'h0000, "R1 R4 write after leading zeros");
  endtask

  task automatic testSequential();
    writeWord(6'd63, 16'hBEEF, "R8");
    writeWord(6'd0, 16'h0F0F, "R8");
    readWords(6'd63, 2, 16'hBEEF, 16'h0F0F, "R3 sequential read wrap");
  endtask

  task automatic testErase();
    logic so;
    csUp();
    sendCmd(2'b11, 6'd5, so);
    progFinish("R5");
    readWords(6'd5, 1, 16'hFFFF, 16'h0000, "R5 erase word");
    readWords(6'd63, 1, 16'hBEEF, 16'h0000, "R5 other word kept");
  endtask

  task automatic testFillWipe();
    logic so;
    csUp();
    sendCmd(2'b00, 6'b010000, so);
    sendData(16'h3C3C);
    progFinish("R6");
    readWords(6'd17, 1, 16'h3C3C, 16'h0000, "R6 fill word 17");
    readWords(6'd63, 1, 16'h3C3C, 16'h0000, "R6 fill word 63");
    csUp();
    sendCmd(2'b00, 6'b100000, so);
    progFinish("R6");
    readWords(6'd40, 1, 16'hFFFF, 16'h0000, "R6 wipe word 40");
  endtask

  task automatic testAbort();
    logic so;
    csUp();
    sendCmd(2'b01, 6'd2, so);
    for (int i = 0; i < 8; i++) pulse(1'b0, so);
    csDown();
    check("R9 abort write enable", {15'd0, serOutEn}, 16'd0);
    readWords(6'd2, 1, 16'hFFFF, 16'h0000, "R9 aborted write");
    csUp();
    sendCmd(2'b10, 6'd2, so);
    for (int i = 0; i < 5; i++) pulse(1'b0, so);
    csDown();
    check("R9 abort read enable", {15'd0, serOutEn}, 16'd0);
    check("R9 abort read level", {15'd0, serOut}, 16'd0);
  endtask

  task automatic testRelock();
    ext(2'b00);
    writeWord(6'd9, 16'h1111, "R8");
    readWords(6'd9, 1, 16'hFFFF, 16'h0000, "R7 write after lock");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; chipSel = 1'b0; serClk = 1'b0; serIn = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(2);
    testReset();
    testLocked();
    testLeadingZeros();
    testSequential();
    testErase();
    testFillWipe();
    testAbort();
    testRelock();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule